// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits load current by chopping the gate drive one cycle at a time. While drive is requested the gate enable is on. When a current comparator reports that the load current has crossed its threshold, the gate enable is dropped for a fixed off-time chosen from four lengths. When that time runs out, drive comes back if it is still requested. The comparator, the current mirror and the threshold converter sit outside this block. The trip reaches it as a synchronous digital level.

When the bridge recirculates on its low side, a leading-edge blanking window follows every turn-on of the gate. Turn-on happens on a fresh drive request and after each off-time. Trips inside the window are ignored, so that switching spikes cannot start a false off-time. There are two window lengths. With high-side recirculation there is no blanking, and a trip counts from the first enabled cycle. A status output is high for exactly the cycles of an off-time.

All time is counted in clock cycles. A tick is `TICK_NS` nanoseconds long and equals `CYC_PER_TICK` clocks. The default tick is 100 ns at 5 clocks per tick. The hardware-strapped setting uses off-time code 01 and blanking code 0.

Top module: `off_time_chopper`

## Requirements
- R1: During and right after reset, `gate_en_o` and `chop_active_o` are both 0.
- R2: From idle, `drive_req_i` = 1 turns `gate_en_o` on in the next cycle. Outside an off-time, `drive_req_i` = 0 turns `gate_en_o` off in the next cycle and starts no off-time, even if a trip arrives in the same cycle.
- R3: A trip that arrives while the gate is enabled and blanking is not active sets `gate_en_o` to 0 and `chop_active_o` to 1 in the next cycle.
- R4: The off-time lasts (200 + 100·`toff_sel_i`) ticks, sampled when the off-time starts. At the defaults, codes 00, 01, 10 and 11 give 20, 30, 40 and 50 µs, that is 1000, 1500, 2000 and 2500 clocks.
- R5: A trip during an off-time, including in its last cycle, neither extends it nor restarts it.
- R6: When an off-time ends, the gate is re-enabled in the next cycle only if `drive_req_i` is 1. Otherwise the block goes idle with both outputs at 0.
- R7: With `ls_recirc_i` = 1, every gate turn-on starts a blanking window, both from idle and after an off-time. Trips inside the window are ignored. The window length, sampled at turn-on, is 24 ticks for `tblank_sel_i` = 0 and 34 ticks for 1. At the defaults this is 120 or 170 clocks.
- R8: With `ls_recirc_i` = 0 there is no blanking, and a trip in the first enabled cycle already starts an off-time.
- R9: `chop_active_o` is 1 exactly during off-time cycles. It is never 1 in a cycle where `gate_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drive_req_i | input | 1 | Request to drive the load |
| trip_i | input | 1 | Current over threshold, synchronous |
| ls_recirc_i | input | 1 | 1 = low-side recirculation, which enables blanking |
| toff_sel_i | input | 2 | Off-time code |
| tblank_sel_i | input | 1 | Blanking length code |
| gate_en_o | output | 1 | Gate-drive enable |
| chop_active_o | output | 1 | High during an off-time |

## Verification
Several pairs of events can land on the same clock edge.

- **Window edges:** a trip can coincide with the last cycle of a blanking window or with the first cycle after it. Trips are placed on exactly those cycles. The bench expects the first to be ignored and the second to start an off-time one cycle later.
- **End of an off-time:** a trip can also coincide with the final off-time cycle. The bench expects the gate to come back on schedule, with no second off-time.
- **Request withdrawn:** a trip can land in the same cycle that `drive_req_i` falls. The bench expects the withdrawal to win: the gate drops and `chop_active_o` stays low.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_ON    = 2'd2,
    ST_OFF   = 2'd3
  } chop_state_e;

  // off-time: 20 us + 10 us per code step
  function automatic int unsigned toff_cycles(int unsigned code, int unsigned tick_ns,
                                              int unsigned cpt);
    return ((20000 + 10000 * code) / tick_ns) * cpt;
  endfunction

  function automatic int unsigned blank_cycles(int unsigned sel, int unsigned tick_ns,
                                               int unsigned cpt);
    return (((sel != 0) ? 3400 : 2400) / tick_ns) * cpt;
  endfunction

endpackage

// File: rtl/chop_dur_sel.sv
module chop_dur_sel import chop_pkg::*; #(
  parameter int unsigned TICK_NS      = 100,
  parameter int unsigned CYC_PER_TICK = 5,
  parameter int unsigned CNT_W        = 12
) (
  input  logic [1:0]       toff_sel_i,
  input  logic             tblank_sel_i,
  input  logic             load_off_i,
  output logic [CNT_W-1:0] load_val_o
);

  logic [CNT_W-1:0] toff_tab [4];
  logic [CNT_W-1:0] blank_tab [2];

  // terminal values are length-1 so a load plus N-1 decrements spans N cycles
  for (genvar g = 0; g < 4; g++) begin : g_toff
    assign toff_tab[g] = CNT_W'(toff_cycles(g, TICK_NS, CYC_PER_TICK) - 1);
  end
  for (genvar g = 0; g < 2; g++) begin : g_blank
    assign blank_tab[g] = CNT_W'(blank_cycles(g, TICK_NS, CYC_PER_TICK) - 1);
  end

  assign load_val_o = load_off_i ? toff_tab[toff_sel_i] : blank_tab[tblank_sel_i];

endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm import chop_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        drive_req_i,
  input  logic        trip_i,
  input  logic        ls_recirc_i,
  input  logic        done_i,
  output chop_state_e state_o,
  output logic        load_o,
  output logic        load_off_o
);

  chop_state_e state_q, state_d;

  // re-enable path: blank first when recirculating low side
  function automatic chop_state_e enable_state(logic ls);
    return ls ? ST_BLANK : ST_ON;
  endfunction

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_off_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (drive_req_i) begin
        state_d = enable_state(ls_recirc_i);
        load_o  = ls_recirc_i;
      end
      ST_BLANK: begin
        if (!drive_req_i)  state_d = ST_IDLE;
        else if (done_i)   state_d = ST_ON;
      end
      ST_ON: begin
        if (!drive_req_i) state_d = ST_IDLE;   // withdrawal beats trip
        else if (trip_i) begin
          state_d    = ST_OFF;
          load_o     = 1'b1;
          load_off_o = 1'b1;
        end
      end
      ST_OFF: if (done_i) begin
        if (drive_req_i) begin
          state_d = enable_state(ls_recirc_i);
          load_o  = ls_recirc_i;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/off_time_chopper.sv
module off_time_chopper import chop_pkg::*; #(
  parameter int unsigned TICK_NS      = 100,
  parameter int unsigned CYC_PER_TICK = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       drive_req_i,
  input  logic       trip_i,
  input  logic       ls_recirc_i,
  input  logic [1:0] toff_sel_i,
  input  logic       tblank_sel_i,
  output logic       gate_en_o,
  output logic       chop_active_o
);

  localparam int unsigned MAX_CYC = toff_cycles(3, TICK_NS, CYC_PER_TICK);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  chop_state_e      state_q;
  logic             load, load_off, done;
  logic [CNT_W-1:0] load_val;

  chop_dur_sel #(
    .TICK_NS     (TICK_NS),
    .CYC_PER_TICK(CYC_PER_TICK),
    .CNT_W       (CNT_W)
  ) u_dur (
    .toff_sel_i  (toff_sel_i),
    .tblank_sel_i(tblank_sel_i),
    .load_off_i  (load_off),
    .load_val_o  (load_val)
  );

  chop_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drive_req_i(drive_req_i),
    .trip_i     (trip_i),
    .ls_recirc_i(ls_recirc_i),
    .done_i     (done),
    .state_o    (state_q),
    .load_o     (load),
    .load_off_o (load_off)
  );

  chop_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .done_o    (done)
  );

  assign gate_en_o     = (state_q == ST_BLANK) || (state_q == ST_ON);
  assign chop_active_o = (state_q == ST_OFF);

endmodule

// File: rtl/off_time_chopper_chk.sv
module off_time_chopper_chk import chop_pkg::*; #(
  parameter int unsigned TICK_NS      = 100,
  parameter int unsigned CYC_PER_TICK = 5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        drive_req_i,
  input logic        trip_i,
  input logic [1:0]  toff_sel_i,
  input logic        gate_en_o,
  input logic        chop_active_o,
  input chop_state_e state_q
);

  localparam int unsigned LEN_W = 16;

  logic [LEN_W-1:0] off_len_q;
  logic [1:0]       code_q;
  logic [LEN_W-1:0] exp_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_len_q <= '0;
      code_q    <= '0;
    end else if (!chop_active_o) begin
      off_len_q <= LEN_W'(1);
      code_q    <= toff_sel_i;
    end else begin
      off_len_q <= off_len_q + LEN_W'(1);
    end
  end

  assign exp_len = LEN_W'(toff_cycles(32'(code_q), TICK_NS, CYC_PER_TICK));

  assert_req_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_req_i |=> !gate_en_o);

  assert_trip_cuts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && drive_req_i && trip_i) |=> (chop_active_o && !gate_en_o));

  assert_off_early_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chop_active_o && off_len_q < exp_len) |=> chop_active_o);

  assert_off_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chop_active_o && off_len_q == exp_len) |=> !chop_active_o);

  assert_resume_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chop_active_o) |-> (gate_en_o == $past(drive_req_i)));

  assert_blank_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BLANK && drive_req_i && trip_i) |=> gate_en_o);

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_en_o && chop_active_o));

endmodule

bind off_time_chopper off_time_chopper_chk #(
  .TICK_NS     (TICK_NS),
  .CYC_PER_TICK(CYC_PER_TICK)
) u_chk (.*);

// File: tb/off_time_chopper_tb.sv
module off_time_chopper_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       trip = 1'b0;
  logic       ls = 1'b0;
  logic [1:0] toff = 2'b01;
  logic       tblank = 1'b0;
  logic       gate, act;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    cyc;
    logic  gate;
    logic  act;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  off_time_chopper u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .drive_req_i  (req),
    .trip_i       (trip),
    .ls_recirc_i  (ls),
    .toff_sel_i   (toff),
    .tblank_sel_i (tblank),
    .gate_en_o    (gate),
    .chop_active_o(act)
  );

  task automatic push(int c, logic g, logic a, string tag);
    exp_t e;
    e.cyc = c; e.gate = g; e.act = a; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step_to(int c);
    while (cyc < c) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic trip_at(int c);
    step_to(c);
    trip = 1'b1;
    step_to(c + 1);
    trip = 1'b0;
  endtask

  // monitor: compare scheduled expectations mid-cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      mon_e = exp_q.pop_front();
      checks++;
      if (mon_e.cyc != cyc || gate !== mon_e.gate || act !== mon_e.act) begin
        errors++;
        $display("FAIL %s cyc %0d: gate=%b act=%b expected gate=%b act=%b",
                 mon_e.tag, mon_e.cyc, gate, act, mon_e.gate, mon_e.act);
      end
    end
  end

  // off-time scenario, no blanking; poke adds trips inside the off-time (R5)
  task automatic run_off(logic [1:0] code, int n, bit poke);
    int b;
    toff = code;
    ls   = 1'b0;
    b = cyc + 2;
    push(b + 1, 1'b1, 1'b0, "R2");
    push(b + 11, 1'b0, 1'b1, "R3");
    push(b + 10 + n, 1'b0, 1'b1, "R4");
    push(b + 11 + n, 1'b1, 1'b0, poke ? "R5" : "R4");
    push(b + 16 + n, 1'b0, 1'b0, "R2");
    step_to(b);
    req = 1'b1;
    trip_at(b + 10);
    if (poke) begin
      trip_at(b + 500);
      trip_at(b + 10 + n);
    end
    step_to(b + 15 + n);
    req = 1'b0;
    step_to(b + 20 + n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int b;
    repeat (3) @(negedge clk);
    checks++;
    if (gate !== 1'b0 || act !== 1'b0) begin
      errors++;
      $display("FAIL R1: gate=%b act=%b expected gate=0 act=0", gate, act);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    b = cyc + 2;
    push(b, 1'b0, 1'b0, "R1");
    step_to(b + 2);

    // R4 all four off-time codes, R5 trips during off-time
    run_off(2'b01, 1500, 1'b1);
    run_off(2'b00, 1000, 1'b0);
    run_off(2'b10, 2000, 1'b0);
    run_off(2'b11, 2500, 1'b0);

    // R8 no blanking: trip in first enabled cycle; R6 request gone at expiry
    toff = 2'b00;
    ls   = 1'b0;
    b = cyc + 2;
    push(b + 1, 1'b1, 1'b0, "R8");
    push(b + 2, 1'b0, 1'b1, "R8");
    push(b + 1001, 1'b0, 1'b1, "R6");
    push(b + 1002, 1'b0, 1'b0, "R6");
    step_to(b);
    req = 1'b1;
    trip_at(b + 1);
    step_to(b + 3);
    req = 1'b0;
    step_to(b + 1010);

    // R7 short blanking window, restart after off-time
    ls     = 1'b1;
    tblank = 1'b0;
    b = cyc + 2;
    push(b + 1, 1'b1, 1'b0, "R7");
    push(b + 52, 1'b1, 1'b0, "R7");
    push(b + 122, 1'b1, 1'b0, "R7");
    push(b + 126, 1'b0, 1'b1, "R3");
    push(b + 1125, 1'b0, 1'b1, "R4");
    push(b + 1126, 1'b1, 1'b0, "R6");
    push(b + 1202, 1'b1, 1'b0, "R7");
    push(b + 1247, 1'b0, 1'b1, "R7");
    push(b + 2246, 1'b0, 1'b1, "R6");
    push(b + 2247, 1'b0, 1'b0, "R6");
    step_to(b);
    req = 1'b1;
    trip_at(b + 50);
    trip_at(b + 120);
    trip_at(b + 125);
    trip_at(b + 1200);
    trip_at(b + 1246);
    step_to(b + 1250);
    req = 1'b0;
    step_to(b + 2255);

    // R7 long blanking window edges
    tblank = 1'b1;
    b = cyc + 2;
    push(b + 1, 1'b1, 1'b0, "R7");
    push(b + 171, 1'b1, 1'b0, "R7");
    push(b + 172, 1'b0, 1'b1, "R7");
    push(b + 1172, 1'b0, 1'b0, "R6");
    step_to(b);
    req = 1'b1;
    trip_at(b + 170);
    trip_at(b + 171);
    step_to(b + 175);
    req = 1'b0;
    step_to(b + 1180);

    // R2 withdrawal and trip in the same cycle
    ls = 1'b0;
    b = cyc + 2;
    push(b + 1, 1'b1, 1'b0, "R2");
    push(b + 21, 1'b0, 1'b0, "R2");
    push(b + 22, 1'b0, 1'b0, "R9");
    step_to(b);
    req = 1'b1;
    step_to(b + 20);
    req  = 1'b0;
    trip = 1'b1;
    step_to(b + 21);
    trip = 1'b0;
    step_to(b + 30);

    while (exp_q.size() > 0) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule